// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a copy of every word of a one-time-programmable fuse array in flip-flops, so that software and hardware readers see fuse contents in a single cycle. The fuse array is not fast: it answers a word address only after a fixed read latency. Reads therefore never go to it directly. A reload sequencer walks the array, reads each fuse word and writes it into the matching shadow register. A reload runs automatically after reset and can be requested again by software.

Software reaches the bank through a simple register port. A control word sits at the bottom of the map, together with a set alias and a clear alias. The shadow words sit in a strided window above it. Two per-word lock vectors gate access. A read-locked word answers with a poison pattern. A write-locked word ignores writes. Either violation raises one shared, sticky error flag. The flag also catches a shadow write made while a reload is running. While the flag is set, the bank starts nothing new until software clears it.

The read data port has no back-pressure. Every read request is answered on the next cycle with `bus_rvalid` high for one cycle. The requester must take the data in that cycle. Writes complete in the cycle they are presented and return nothing.

Top module: `fuse_shadow_bank`

## Requirements
- R1: A read of address 0x000 returns the control word. In this word, bit 8 is busy, bit 9 is the error flag and bit 10 is reload-active. Every other bit reads 0.
- R2: Shadow word i sits at byte address 0x400 + 0x10*i, for i below NWORDS. Every read is answered with `bus_rvalid` high exactly one cycle after the request. Reads of any address outside the control word and the shadow window return 0. Writes to such addresses change nothing.
- R3: Reset clears every shadow word to 0 and starts a reload at once. Busy is high in the first cycle after reset.
- R4: Writing a 1 in bit 10 to the set alias at 0x004 starts a reload, provided the bank is idle and the error flag is clear. Busy and reload-active stay high until every shadow has been refreshed. After that, each shadow holds its fuse word.
- R5: A reload visits the words in ascending index order and spends LAT+1 cycles on each word. Shadow reads during a reload are answered in one cycle with the current shadow contents. A word not yet reached keeps its old value.
- R6: Fuse word i holds FUSE_SEED XOR (i * 0x9E3779B1), computed modulo 2^32.
- R7: A read of a word whose `rd_lock` bit is set returns 0xBADABADA and sets the error flag.
- R8: A shadow write while a reload is active sets the error flag and leaves the shadow unchanged.
- R9: A shadow write to a word whose `wr_lock` bit is set sets the error flag and is discarded.
- R10: While the error flag is set, shadow reads return 0xBADABADA and change nothing, shadow writes are discarded, and reload requests are ignored. Writing a 1 in bit 9 to the clear alias at 0x008 clears the flag.
- R11: A shadow write to an unlocked word, made while the bank is idle and error-free, replaces the word. The new value reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |
| busy_o | output | 1 | Reload in progress |
| err_o | output | 1 | Sticky error flag |

## Verification
The shadow window is read with several address patterns: the lowest word, the highest word, middle words, and addresses that are unaligned or lie between the regions. These patterns separate correct decode from off-by-one or stride mistakes. Accesses are tested under each gating condition in turn: idle, reload running, word locked, and error flag set. Each of these cases shows whether a shadow changes and whether the flag rises. One reload is stopped partway through by reading the first and last words. That read distinguishes ascending order from other visit orders, and reads of live contents from stale ones.

// File: rtl/fuse_shadow_pkg.sv
package fuse_shadow_pkg;
  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;
  localparam int unsigned WIN_BASE    = 'h400;
  localparam int unsigned CTRL_ADDR   = 'h000;
  localparam int unsigned SET_ADDR    = 'h004;
  localparam int unsigned CLR_ADDR    = 'h008;
  localparam int unsigned BIT_BUSY    = 8;
  localparam int unsigned BIT_ERR     = 9;
  localparam int unsigned BIT_RELOAD  = 10;
  localparam logic [31:0] FUSE_MIX    = 32'h9E37_79B1;

  // Content model of the fuse array: seed mixed with a golden-ratio stride.
  function automatic logic [31:0] fuse_word(input logic [31:0] seed,
                                            input logic [31:0] idx);
    logic [31:0] prod;
    prod = idx * FUSE_MIX;
    return seed ^ prod;
  endfunction
endpackage

// File: rtl/fuse_shadow_array.sv
// Fuse array model: word address in, data out LAT cycles later.
module fuse_shadow_array #(
  parameter int          NWORDS    = 64,
  parameter int          LAT       = 3,
  parameter logic [31:0] FUSE_SEED = 32'hC0DE_0000,
  localparam int         IW        = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] addr,
  output logic [31:0]   rdata
);
  import fuse_shadow_pkg::*;

  logic [31:0] stage_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage_q[s] <= '0;
      else if (s == 0)
        stage_q[s] <= fuse_word(FUSE_SEED, 32'(addr));
      else
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rdata = stage_q[LAT-1];
endmodule

// File: rtl/fuse_shadow_reload.sv
// Reload sequencer: ascending walk, LAT+1 cycles per word.
module fuse_shadow_reload #(
  parameter int  NWORDS = 64,
  parameter int  LAT    = 3,
  localparam int IW     = $clog2(NWORDS),
  localparam int CW     = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] word_idx,
  output logic          load_en
);
  localparam logic [CW-1:0] CNT_LAST = CW'(LAT);
  localparam logic [IW-1:0] IDX_LAST = IW'(NWORDS - 1);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (idx_q == IDX_LAST) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end
  end

  assign busy     = busy_q;
  assign word_idx = idx_q;
  assign load_en  = busy_q && (cnt_q == CNT_LAST);
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int          NWORDS    = 64,
  parameter int          LAT       = 3,
  parameter int          AW        = 12,
  parameter logic [31:0] FUSE_SEED = 32'hC0DE_0000,
  localparam int         IW        = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic [NWORDS-1:0] rd_lock,
  input  logic [NWORDS-1:0] wr_lock,
  output logic              busy_o,
  output logic              err_o
);
  import fuse_shadow_pkg::*;

  localparam logic [AW-1:0]   BASE_A = AW'(WIN_BASE);
  localparam logic [AW-5:0]   NW_A   = (AW-4)'(NWORDS);

  // ---------------- address decode ----------------
  logic [AW-1:0] off;
  logic          win_hit, ctrl_hit, set_hit, clr_hit;
  logic [IW-1:0] widx;

  assign off      = bus_addr - BASE_A;
  assign win_hit  = (bus_addr >= BASE_A) && (off[3:0] == 4'h0) && (off[AW-1:4] < NW_A);
  assign widx     = off[IW+3:4];
  assign ctrl_hit = bus_addr == AW'(CTRL_ADDR);
  assign set_hit  = bus_addr == AW'(SET_ADDR);
  assign clr_hit  = bus_addr == AW'(CLR_ADDR);

  logic rd_win, wr_win;
  assign rd_win = bus_req && !bus_we && win_hit;
  assign wr_win = bus_req &&  bus_we && win_hit;

  // ---------------- reload engine ----------------
  logic          err_q;
  logic          rl_busy, rl_load, rl_start;
  logic [IW-1:0] rl_idx;
  logic [31:0]   fuse_data;

  assign rl_start = bus_req && bus_we && set_hit && bus_wdata[BIT_RELOAD] && !err_q;

  fuse_shadow_reload #(.NWORDS(NWORDS), .LAT(LAT)) u_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rl_start),
    .busy     (rl_busy),
    .word_idx (rl_idx),
    .load_en  (rl_load)
  );

  fuse_shadow_array #(.NWORDS(NWORDS), .LAT(LAT), .FUSE_SEED(FUSE_SEED)) u_fuse (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (rl_idx),
    .rdata (fuse_data)
  );

  // ---------------- error flag ----------------
  logic wr_fault, rd_fault, wr_ok, err_clr;
  assign wr_fault = wr_win && !err_q && (rl_busy || wr_lock[widx]);
  assign rd_fault = rd_win && !err_q && rd_lock[widx];
  assign wr_ok    = wr_win && !err_q && !rl_busy && !wr_lock[widx];
  assign err_clr  = bus_req && bus_we && clr_hit && bus_wdata[BIT_ERR];

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_q <= 1'b0;
    else if (err_clr)              err_q <= 1'b0;
    else if (wr_fault || rd_fault) err_q <= 1'b1;
  end

  // ---------------- shadow storage ----------------
  logic [31:0] shadow_q [NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow_q[i] <= '0;
    end else if (rl_load) begin
      shadow_q[rl_idx] <= fuse_data;
    end else if (wr_ok) begin
      shadow_q[widx] <= bus_wdata;
    end
  end

  // ---------------- read path ----------------
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (ctrl_hit) begin
      rd_next[BIT_BUSY]   = rl_busy;
      rd_next[BIT_ERR]    = err_q;
      rd_next[BIT_RELOAD] = rl_busy;
    end else if (win_hit) begin
      if (err_q || rd_lock[widx]) rd_next = POISON_WORD;
      else                        rd_next = shadow_q[widx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      bus_rdata  <= (bus_req && !bus_we) ? rd_next : '0;
    end
  end

  assign busy_o = rl_busy;
  assign err_o  = err_q;
endmodule

// File: rtl/fuse_shadow_bank_chk.sv
module fuse_shadow_bank_chk #(
  parameter int NWORDS = 64,
  parameter int AW     = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic [NWORDS-1:0] rd_lock,
  input logic              busy_o,
  input logic              err_o
);
  localparam int IW = $clog2(NWORDS);

  logic [AW-1:0] c_off;
  logic          c_hit, c_set, c_clr;
  logic [IW-1:0] c_idx;
  assign c_off = bus_addr - AW'('h400);
  assign c_hit = (bus_addr >= AW'('h400)) && (c_off[3:0] == 4'h0) &&
                 (c_off[AW-1:4] < (AW-4)'(NWORDS));
  assign c_idx = c_off[IW+3:4];
  assign c_set = bus_req && bus_we && (bus_addr == AW'('h004)) && bus_wdata[10];
  assign c_clr = bus_req && bus_we && (bus_addr == AW'('h008)) && bus_wdata[9];

  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  p_poison_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && c_hit && rd_lock[c_idx]) |=> (bus_rdata == 32'hBADA_BADA) && err_o);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set && !busy_o && !err_o) |=> busy_o);

  p_wr_busy_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && c_hit && busy_o) |=> err_o);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !c_clr) |=> err_o);

  p_err_blocks_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !busy_o) |=> !busy_o);
endmodule

bind fuse_shadow_bank fuse_shadow_bank_chk #(.NWORDS(NWORDS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .rd_lock    (rd_lock),
  .busy_o     (busy_o),
  .err_o      (err_o)
);

// File: tb/fuse_shadow_bank_tb.sv
module fuse_shadow_bank_tb;
  localparam int          NW   = 64;
  localparam int          LAT  = 3;
  localparam int          AW   = 12;
  localparam logic [31:0] SEED = 32'hC0DE_0000;
  localparam logic [31:0] BAD  = 32'hBADA_BADA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NW-1:0] rd_lock = '0, wr_lock = '0;
  logic          busy_o, err_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fuse_shadow_bank #(.NWORDS(NW), .LAT(LAT), .AW(AW), .FUSE_SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .rd_lock(rd_lock), .wr_lock(wr_lock),
    .busy_o(busy_o), .err_o(err_o));

  function automatic logic [31:0] fexp(input int i);
    logic [31:0] p;
    p = 32'(i) * 32'h9E37_79B1;
    return SEED ^ p;
  endfunction

  function automatic logic [AW-1:0] waddr(input int i);
    return AW'('h400 + 'h10 * i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy_o; k++) @(negedge clk);
  endtask

  task automatic clr_err();
    wr(AW'('h008), 32'h0000_0200);
  endtask

  // R3 R1 R5: reset state, live reads during the automatic reload
  task automatic t_reset();
    logic [31:0] d; logic v;
    @(negedge clk);
    check("R3 busy after reset", 32'(busy_o), 32'd1);
    rd(waddr(NW-1), d, v);
    check("R3 shadow cleared", d, 32'h0);
    check("R2 rvalid", 32'(v), 32'd1);
    rd(AW'('h000), d, v);
    check("R1 ctrl during reload", d, 32'h0000_0500);
    wait_idle();
    rd(AW'('h000), d, v);
    check("R1 ctrl idle", d, 32'h0);
  endtask

  // R4 R6: fuse contents after reload, low/high/middle words
  task automatic t_contents();
    logic [31:0] d; logic v;
    rd(waddr(0), d, v);    check("R6 word 0", d, fexp(0));
    rd(waddr(NW-1), d, v); check("R6 last word", d, fexp(NW-1));
    rd(waddr(17), d, v);   check("R4 word 17", d, fexp(17));
    rd(waddr(42), d, v);   check("R4 word 42", d, fexp(42));
  endtask

  // R11 R2: normal write, out-of-window accesses
  task automatic t_write_decode();
    logic [31:0] d; logic v;
    wr(waddr(5), 32'h1234_5678);
    rd(waddr(5), d, v);          check("R11 write readback", d, 32'h1234_5678);
    rd(AW'('h404), d, v);        check("R2 unaligned reads 0", d, 32'h0);
    wr(AW'('h408 + 'h10 * 6), 32'hFFFF_FFFF);
    rd(waddr(6), d, v);          check("R2 stray write ignored", d, fexp(6));
    rd(AW'('h3F0), d, v);        check("R2 below window reads 0", d, 32'h0);
  endtask

  // R5 R8: ascending order, write during reload rejected
  task automatic t_reload_order();
    logic [31:0] d; logic v;
    wr(waddr(0), 32'hAAAA_0000);
    wr(waddr(NW-1), 32'hBBBB_FFFF);
    wr(AW'('h004), 32'h0000_0400);
    check("R4 busy after set", 32'(busy_o), 32'd1);
    repeat (3 * (LAT + 1)) @(negedge clk);
    rd(waddr(0), d, v);     check("R5 first word refreshed", d, fexp(0));
    rd(waddr(NW-1), d, v);  check("R5 last word not yet", d, 32'hBBBB_FFFF);
    wr(waddr(NW-1), 32'hDEAD_0001);
    check("R8 error on write in reload", 32'(err_o), 32'd1);
    clr_err();
    rd(waddr(NW-1), d, v);  check("R8 shadow unchanged", d, 32'hBBBB_FFFF);
    wait_idle();
    rd(waddr(NW-1), d, v);  check("R4 last refreshed", d, fexp(NW-1));
  endtask

  // R9 R7 R10: locks and the error state
  task automatic t_locks();
    logic [31:0] d; logic v;
    wr_lock[3] = 1'b1;
    wr(waddr(3), 32'h5555_5555);
    check("R9 error on locked write", 32'(err_o), 32'd1);
    clr_err();
    check("R10 clear alias", 32'(err_o), 32'd0);
    rd(waddr(3), d, v);  check("R9 write discarded", d, fexp(3));
    wr_lock[3] = 1'b0;
    rd_lock[9] = 1'b1;
    rd(waddr(9), d, v);  check("R7 poison", d, BAD);
    check("R7 error set", 32'(err_o), 32'd1);
    rd(waddr(8), d, v);  check("R10 poison while error", d, BAD);
    wr(waddr(4), 32'h7777_7777);
    wr(AW'('h004), 32'h0000_0400);
    @(negedge clk);
    check("R10 reload ignored", 32'(busy_o), 32'd0);
    rd(AW'('h000), d, v); check("R1 ctrl error bit", d, 32'h0000_0200);
    clr_err();
    rd(waddr(4), d, v);  check("R10 write discarded", d, fexp(4));
    rd(waddr(8), d, v);  check("R10 normal after clear", d, fexp(8));
    rd_lock[9] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_contents();
    t_write_decode();
    t_reload_order();
    t_locks();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule